// File: doc/BRIEF.md
# TPM Locality Claim Sequencer

This block runs the start-up handshake with a TPM 2.0 device that sits behind a register transaction engine. After a one-cycle `start` pulse it walks a fixed chain of register accesses. It reads the identification word and inspects the access register. If a locality was left active, it releases it first. It then requests locality 0 and verifies the grant, checks the interface family field of the status register and finally fetches the revision byte. The results are the vendor ID, the device ID and the revision, with `ready` set when the whole chain succeeded.

The block talks to the transaction engine over a request/response pair. A request carries a register offset, a write flag, a byte count and, for writes, a single data byte. It is held until the engine accepts it. Read data then comes back one byte per `rsp_valid` beat, least significant byte first, for as many beats as the byte count. A write is acknowledged by a single beat whose data is ignored. When any check fails, the block stops issuing requests, raises `error` and holds a reason code until the next start.

Top module: `tpm_locality_claim`

## Requirements
- R1: After an accepted start, the first request is a 4-byte read at offset 0xF00. The bytes are assembled least significant first. Bits 15:0 become `vendor_id` and bits 31:16 become `device_id`.
- R2: The second request is a 1-byte read of the access register at offset 0x00. In that register, bit 7 is valid, bit 5 is active locality, bit 1 is request use and bit 0 is establishment.
- R3: If that first access value has both bit 7 and bit 5 set, the block writes 0x20 (1 byte) to offset 0x00 and then reads offset 0x00 again. Otherwise it issues neither of these requests.
- R4: The last access value read before the claim, with bit 0 ignored, must equal exactly 0x80. Any other value stops the sequence with `err_code` 1 (reset status).
- R5: The block writes 0x02 to offset 0x00 and reads offset 0x00 back. With bit 0 ignored, the value must equal 0xA0. Otherwise the sequence stops with `err_code` 2 (claim failed).
- R6: The block reads 4 bytes at offset 0x18. Bits 27:26 of that word must equal 1. Otherwise the sequence stops with `err_code` 3 (wrong family).
- R7: The block reads 1 byte at offset 0xF04 into `revision` and only then raises `ready`, with `error` low and `err_code` 0.
- R8: After an error, no further request is issued. `error` stays high with its code unchanged until the next start. `ready` and `error` are never high together.
- R9: A start pulse is taken only when the block is idle, finished or failed. It clears `ready`, `error`, `err_code` and the captured IDs. A start pulse while a sequence runs has no effect.
- R10: While `req_valid` is high and `req_ready` is low, all request fields are held stable. No new request is raised while a response is outstanding. A read completes after as many beats as its length, and a write completes after one beat.
- R11: Out of reset, `ready`, `error`, `err_code` and `req_valid` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle pulse that begins the handshake |
| req_valid | output | 1 | A register request is offered |
| req_ready | input | 1 | Engine accepts the offered request |
| req_write | output | 1 | 1 = register write, 0 = register read |
| req_addr | output | 16 | Register offset |
| req_len | output | 3 | Byte count of the transfer (1 or 4) |
| req_wdata | output | 8 | Byte to write (writes only) |
| rsp_valid | input | 1 | One response byte (or write acknowledge) is present |
| rsp_data | input | 8 | Response byte, least significant first |
| vendor_id | output | 16 | Captured vendor identifier |
| device_id | output | 16 | Captured device identifier |
| revision | output | 8 | Captured revision byte |
| ready | output | 1 | Handshake completed successfully |
| error | output | 1 | Handshake stopped on a failed check |
| err_code | output | 2 | 0 none, 1 reset status, 2 claim failed, 3 wrong family |

## Verification
The properties assume that the engine sends response beats only while a request is outstanding and never sends more beats than the request's byte count. They also assume that `start` is a single-cycle pulse. The bench's responder keeps to this. It raises `rsp_valid` only after it has accepted a request, gives exactly the requested number of beats, and sometimes inserts idle cycles before acceptance and between beats. Device behaviour is varied through the initial access value, the value left after a release, whether the claim is granted and the family field. One run also pulses `start` while a request is stalled.

// File: rtl/tpmloc_pkg.sv
package tpmloc_pkg;

  localparam int REG_AW     = 16;
  localparam int ID_W       = 16;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = WORD_BYTES * 8;
  localparam int LEN_W      = $clog2(WORD_BYTES + 1);
  localparam int FAM_LSB    = 26;

  localparam logic [1:0] FAM_TPM2 = 2'd1;

  localparam logic [7:0] ACC_VALID   = 8'h80;
  localparam logic [7:0] ACC_ACTIVE  = 8'h20;
  localparam logic [7:0] ACC_REQUEST = 8'h02;
  localparam logic [7:0] ACC_ESTAB   = 8'h01;

  localparam logic [REG_AW-1:0] OFF_ACCESS = 16'h0000;
  localparam logic [REG_AW-1:0] OFF_STATUS = 16'h0018;
  localparam logic [REG_AW-1:0] OFF_IDENT  = 16'h0F00;
  localparam logic [REG_AW-1:0] OFF_REVN   = 16'h0F04;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_IDENT,
    ST_ACC_FIRST,
    ST_RELEASE,
    ST_ACC_AGAIN,
    ST_REQUEST,
    ST_ACC_CLAIM,
    ST_STATUS,
    ST_REVN,
    ST_READY,
    ST_FAIL
  } step_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_RESET  = 2'd1,
    FLT_CLAIM  = 2'd2,
    FLT_FAMILY = 2'd3
  } fault_e;

  // Access value with the establishment flag dropped.
  function automatic logic [7:0] drop_estab(input logic [7:0] b);
    return b & ~ACC_ESTAB;
  endfunction

  // A locality was left active and must be released first.
  function automatic logic stale_locality(input logic [7:0] b);
    return (b & (ACC_VALID | ACC_ACTIVE)) == (ACC_VALID | ACC_ACTIVE);
  endfunction

  function automatic logic reset_clean(input logic [7:0] b);
    return drop_estab(b) == ACC_VALID;
  endfunction

  function automatic logic claim_held(input logic [7:0] b);
    return drop_estab(b) == (ACC_VALID | ACC_ACTIVE);
  endfunction

  function automatic logic family_ok(input logic [WORD_W-1:0] w);
    return w[FAM_LSB +: 2] == FAM_TPM2;
  endfunction

  function automatic logic step_running(input step_e s);
    return !(s == ST_IDLE || s == ST_READY || s == ST_FAIL);
  endfunction

endpackage

// File: rtl/loc_step_decode.sv
module loc_step_decode
  import tpmloc_pkg::*;
(
  input  step_e             step,
  output logic              wr,
  output logic [REG_AW-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic [7:0]        wdata
);

  localparam logic [LEN_W-1:0] LEN_BYTE = LEN_W'(1);
  localparam logic [LEN_W-1:0] LEN_WORD = LEN_W'(WORD_BYTES);

  always_comb begin
    wr    = 1'b0;
    addr  = OFF_ACCESS;
    len   = LEN_BYTE;
    wdata = 8'h00;
    unique case (step)
      ST_IDENT: begin
        addr = OFF_IDENT;
        len  = LEN_WORD;
      end
      ST_ACC_FIRST, ST_ACC_AGAIN, ST_ACC_CLAIM: begin
        addr = OFF_ACCESS;
      end
      ST_RELEASE: begin
        wr    = 1'b1;
        wdata = ACC_ACTIVE;
      end
      ST_REQUEST: begin
        wr    = 1'b1;
        wdata = ACC_REQUEST;
      end
      ST_STATUS: begin
        addr = OFF_STATUS;
        len  = LEN_WORD;
      end
      ST_REVN: begin
        addr = OFF_REVN;
      end
      default: begin
        addr = OFF_ACCESS;
      end
    endcase
  end

endmodule

// File: rtl/loc_byte_collector.sv
module loc_byte_collector
  import tpmloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              beat_valid,
  input  logic [7:0]        beat_data,
  input  logic [LEN_W-1:0]  len,
  output logic [WORD_W-1:0] word_now,
  output logic              last_beat
);

  logic [WORD_W-1:0] word_q;
  logic [LEN_W-1:0]  cnt_q;

  // Each lane takes the incoming byte when the beat count points at it.
  for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
    assign word_now[8*g +: 8] =
      (beat_valid && cnt_q == LEN_W'(g)) ? beat_data : word_q[8*g +: 8];
  end

  assign last_beat = beat_valid && ((cnt_q + LEN_W'(1)) == len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clear) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (beat_valid) begin
      word_q <= word_now;
      cnt_q  <= cnt_q + LEN_W'(1);
    end
  end

endmodule

// File: rtl/loc_verdict.sv
module loc_verdict
  import tpmloc_pkg::*;
(
  input  step_e             step,
  input  logic [WORD_W-1:0] word,
  output step_e             next,
  output logic              fail,
  output fault_e            code,
  output logic              take_ids,
  output logic              take_revn
);

  logic [7:0] acc_byte;
  assign acc_byte = word[7:0];

  always_comb begin
    next      = step;
    fail      = 1'b0;
    code      = FLT_NONE;
    take_ids  = 1'b0;
    take_revn = 1'b0;
    unique case (step)
      ST_IDENT: begin
        next     = ST_ACC_FIRST;
        take_ids = 1'b1;
      end
      ST_ACC_FIRST: begin
        if (stale_locality(acc_byte)) next = ST_RELEASE;
        else if (reset_clean(acc_byte)) next = ST_REQUEST;
        else begin
          next = ST_FAIL;
          fail = 1'b1;
          code = FLT_RESET;
        end
      end
      ST_RELEASE: next = ST_ACC_AGAIN;
      ST_ACC_AGAIN: begin
        if (reset_clean(acc_byte)) next = ST_REQUEST;
        else begin
          next = ST_FAIL;
          fail = 1'b1;
          code = FLT_RESET;
        end
      end
      ST_REQUEST: next = ST_ACC_CLAIM;
      ST_ACC_CLAIM: begin
        if (claim_held(acc_byte)) next = ST_STATUS;
        else begin
          next = ST_FAIL;
          fail = 1'b1;
          code = FLT_CLAIM;
        end
      end
      ST_STATUS: begin
        if (family_ok(word)) next = ST_REVN;
        else begin
          next = ST_FAIL;
          fail = 1'b1;
          code = FLT_FAMILY;
        end
      end
      ST_REVN: begin
        next      = ST_READY;
        take_revn = 1'b1;
      end
      default: next = step;
    endcase
  end

endmodule

// File: rtl/tpm_locality_claim.sv
module tpm_locality_claim
  import tpmloc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [REG_AW-1:0] req_addr,
  output logic [LEN_W-1:0]  req_len,
  output logic [7:0]        req_wdata,
  input  logic              rsp_valid,
  input  logic [7:0]        rsp_data,
  output logic [ID_W-1:0]   vendor_id,
  output logic [ID_W-1:0]   device_id,
  output logic [7:0]        revision,
  output logic              ready,
  output logic              error,
  output logic [1:0]        err_code
);

  step_e  step_q;
  logic   issued_q;
  fault_e code_q;

  // Named internal events used by the checker.
  logic seq_busy;
  logic start_ok;
  logic req_fire;
  logic awaiting_rsp;
  logic beat;
  logic xfer_done;

  logic [WORD_W-1:0] word_now;
  step_e  v_next;
  logic   v_fail;
  fault_e v_code;
  logic   v_take_ids;
  logic   v_take_revn;

  assign seq_busy     = step_running(step_q);
  assign start_ok     = start && !seq_busy;
  assign req_valid    = seq_busy && !issued_q;
  assign req_fire     = req_valid && req_ready;
  assign awaiting_rsp = seq_busy && issued_q;
  assign beat         = awaiting_rsp && rsp_valid;
  assign err_code     = code_q;

  loc_step_decode u_decode (
    .step  (step_q),
    .wr    (req_write),
    .addr  (req_addr),
    .len   (req_len),
    .wdata (req_wdata)
  );

  loc_byte_collector u_collect (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (req_fire),
    .beat_valid (beat),
    .beat_data  (rsp_data),
    .len        (req_len),
    .word_now   (word_now),
    .last_beat  (xfer_done)
  );

  loc_verdict u_verdict (
    .step      (step_q),
    .word      (word_now),
    .next      (v_next),
    .fail      (v_fail),
    .code      (v_code),
    .take_ids  (v_take_ids),
    .take_revn (v_take_revn)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q    <= ST_IDLE;
      issued_q  <= 1'b0;
      ready     <= 1'b0;
      error     <= 1'b0;
      code_q    <= FLT_NONE;
      vendor_id <= '0;
      device_id <= '0;
      revision  <= '0;
    end else if (start_ok) begin
      step_q    <= ST_IDENT;
      issued_q  <= 1'b0;
      ready     <= 1'b0;
      error     <= 1'b0;
      code_q    <= FLT_NONE;
      vendor_id <= '0;
      device_id <= '0;
      revision  <= '0;
    end else if (req_fire) begin
      issued_q <= 1'b1;
    end else if (xfer_done) begin
      issued_q <= 1'b0;
      step_q   <= v_next;
      if (v_take_ids) begin
        vendor_id <= word_now[ID_W-1:0];
        device_id <= word_now[2*ID_W-1:ID_W];
      end
      if (v_take_revn) revision <= word_now[7:0];
      if (v_fail) begin
        error  <= 1'b1;
        code_q <= v_code;
      end
      if (v_next == ST_READY) ready <= 1'b1;
    end
  end

endmodule

// File: rtl/loc_claim_chk.sv
module loc_claim_chk
  import tpmloc_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [REG_AW-1:0] req_addr,
  input logic [LEN_W-1:0]  req_len,
  input logic [7:0]        req_wdata,
  input logic              rsp_valid,
  input logic              ready,
  input logic              error,
  input logic [1:0]        err_code,
  input logic              seq_busy,
  input logic              awaiting_rsp
);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr) &&
      $stable(req_write) && $stable(req_len) && $stable(req_wdata));

  // R10
  one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
    awaiting_rsp |-> !req_valid);

  // R8
  ready_error_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ready && error));

  // R8
  error_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error && !start |=> error && $stable(err_code));

  // R8
  error_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> !req_valid && !seq_busy);

  // R4
  error_coded_chk: assert property (@(posedge clk) disable iff (!rst_n)
    error |-> err_code != 2'd0);

  // R9
  busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    seq_busy && start && !rsp_valid |=> seq_busy);

  // R1
  first_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_busy) |-> req_valid && !req_write &&
      req_addr == OFF_IDENT && req_len == LEN_W'(WORD_BYTES));

  // R7
  ready_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(awaiting_rsp && rsp_valid) && err_code == 2'd0);

endmodule

bind tpm_locality_claim loc_claim_chk u_claim_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .start        (start),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .req_len      (req_len),
  .req_wdata    (req_wdata),
  .rsp_valid    (rsp_valid),
  .ready        (ready),
  .error        (error),
  .err_code     (err_code),
  .seq_busy     (seq_busy),
  .awaiting_rsp (awaiting_rsp)
);

// File: tb/tpm_locality_claim_tb_top.sv
module tpm_locality_claim_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        req_valid;
  logic        req_ready = 1'b0;
  logic        req_write;
  logic [15:0] req_addr;
  logic [2:0]  req_len;
  logic [7:0]  req_wdata;
  logic        rsp_valid = 1'b0;
  logic [7:0]  rsp_data = 8'h00;
  logic [15:0] vendor_id;
  logic [15:0] device_id;
  logic [7:0]  revision;
  logic        ready;
  logic        error;
  logic [1:0]  err_code;

  always #5 clk = ~clk;

  tpm_locality_claim dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_len(req_len), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .vendor_id(vendor_id), .device_id(device_id), .revision(revision),
    .ready(ready), .error(error), .err_code(err_code)
  );

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  // Reference model of the observable flags.
  logic       mdl_ready = 1'b0;
  logic       mdl_err = 1'b0;
  logic [1:0] mdl_code = 2'd0;

  // Simulated device register state.
  logic [7:0] dev_acc;
  logic [7:0] dev_rel;
  bit         dev_grant;
  logic [31:0] dev_ident, dev_sts;
  logic [7:0]  dev_rev;

  typedef struct {
    bit          wr;
    logic [15:0] addr;
    int          len;
    logic [7:0]  wd;
    string       tag;
  } exp_t;
  exp_t expq[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // Per-clock comparison against the model (R7, R8, R9, R11).
  always @(negedge clk) begin
    if (rst_n)
      check({ready, error, err_code} == {mdl_ready, mdl_err, mdl_code},
            "R7/R8/R9", "flags per clock",
            {29'd0, ready, error, err_code}, {29'd0, mdl_ready, mdl_err, mdl_code});
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL R10 watchdog expired: actual %0d cycles expected fewer", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  function automatic logic [31:0] dev_read(input logic [15:0] a);
    case (a)
      16'h0000: return {24'h0, dev_acc};
      16'h0018: return dev_sts;
      16'h0F00: return dev_ident;
      16'h0F04: return {24'h0, dev_rev};
      default:  return 32'h0;
    endcase
  endfunction

  task automatic push(input bit wr, input logic [15:0] a, input int len,
                      input logic [7:0] wd, input string tag);
    exp_t e;
    e.wr = wr; e.addr = a; e.len = len; e.wd = wd; e.tag = tag;
    expq.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic run_scn(input string name, input logic [31:0] ident,
                         input logic [7:0] a0, input logic [7:0] arel,
                         input bit grant, input logic [31:0] sts,
                         input logic [7:0] rid, input int gap, input bit poke);
    logic [7:0] a;
    bit   e_ready;
    logic [1:0] e_code;
    int   idx;
    dev_acc = a0; dev_rel = arel; dev_grant = grant;
    dev_ident = ident; dev_sts = sts; dev_rev = rid;
    e_ready = 1'b0; e_code = 2'd0;
    expq.delete();
    // Expected request chain, straight from the requirements.
    push(1'b0, 16'h0F00, 4, 8'h00, "R1");
    push(1'b0, 16'h0000, 1, 8'h00, "R2");
    a = a0;
    if (a[7] && a[5]) begin
      push(1'b1, 16'h0000, 1, 8'h20, "R3");
      push(1'b0, 16'h0000, 1, 8'h00, "R3");
      a = arel;
    end
    if ({a[7:1], 1'b0} != 8'h80) e_code = 2'd1;
    else begin
      push(1'b1, 16'h0000, 1, 8'h02, "R5");
      push(1'b0, 16'h0000, 1, 8'h00, "R5");
      if (grant) a = a | 8'h20;
      if ({a[7:1], 1'b0} != 8'hA0) e_code = 2'd2;
      else begin
        push(1'b0, 16'h0018, 4, 8'h00, "R6");
        if (sts[27:26] != 2'b01) e_code = 2'd3;
        else begin
          push(1'b0, 16'h0F04, 1, 8'h00, "R7");
          e_ready = 1'b1;
        end
      end
    end

    start = 1'b1;
    tick();
    start = 1'b0;
    mdl_ready = 1'b0; mdl_err = 1'b0; mdl_code = 2'd0;

    idx = 0;
    while (expq.size() > 0) begin
      exp_t e;
      logic [31:0] rv;
      while (!req_valid) tick();
      for (int s = 0; s < gap; s++) begin
        if (poke && idx == 2 && s == 0) start = 1'b1;
        tick();
        start = 1'b0;
      end
      e = expq.pop_front();
      check(req_write == e.wr && req_addr == e.addr && int'(req_len) == e.len &&
            (!e.wr || req_wdata == e.wd), e.tag, {name, " request"},
            {req_addr, 1'b0, req_len, 3'b0, req_write, req_wdata},
            {e.addr, 1'b0, 3'(e.len), 3'b0, e.wr, e.wr ? e.wd : req_wdata});
      req_ready = 1'b1;
      tick();
      req_ready = 1'b0;
      if (e.wr) begin
        if (e.wd == 8'h20) dev_acc = dev_rel;
        if (e.wd == 8'h02 && dev_grant) dev_acc = dev_acc | 8'h20;
        rv = 32'h0;
      end else rv = dev_read(e.addr);
      for (int b = 0; b < (e.wr ? 1 : e.len); b++) begin
        if (gap > 0) tick();
        rsp_valid = 1'b1;
        rsp_data = rv[8*b +: 8];
        tick();
        rsp_valid = 1'b0;
        rsp_data = 8'h00;
      end
      if (expq.size() == 0) begin
        mdl_ready = e_ready;
        mdl_err = (e_code != 2'd0);
        mdl_code = e_code;
      end
      idx++;
    end
    repeat (4) begin
      tick();
      check(!req_valid, "R8", {name, " no request after end"}, {31'd0, req_valid}, 32'd0);
    end
    if (e_ready) begin
      check({device_id, vendor_id} == ident, "R1", {name, " ids"},
            {device_id, vendor_id}, ident);
      check(revision == rid, "R7", {name, " revision"}, {24'd0, revision}, {24'd0, rid});
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    check({ready, error, err_code, req_valid} == 5'b0, "R11", "reset outputs",
          {27'd0, ready, error, err_code, req_valid}, 32'd0);
    tick();
    run_scn("clean",        32'h6A3C_15D1, 8'h80, 8'h80, 1, 32'h0400_0090, 8'h3E, 0, 0);
    run_scn("estab",        32'h0102_0304, 8'h81, 8'h81, 1, 32'h0500_0000, 8'h11, 2, 0);
    run_scn("stale",        32'hCAFE_0042, 8'hA0, 8'h80, 1, 32'h0700_0000, 8'h22, 1, 0);
    run_scn("stale_estab",  32'h1111_2222, 8'hA1, 8'h81, 1, 32'h0400_0000, 8'h33, 0, 0);
    run_scn("stale_stuck",  32'h0000_FFFF, 8'hA1, 8'hA1, 1, 32'h0400_0000, 8'h44, 1, 0);
    run_scn("active_only",  32'h5555_AAAA, 8'h20, 8'h20, 1, 32'h0400_0000, 8'h55, 0, 0);
    run_scn("not_valid",    32'h1234_5678, 8'h00, 8'h00, 1, 32'h0400_0000, 8'h66, 0, 0);
    run_scn("claim_denied", 32'h9999_8888, 8'h80, 8'h80, 0, 32'h0400_0000, 8'h77, 1, 0);
    run_scn("family_two",   32'h4321_8765, 8'h80, 8'h80, 1, 32'h0800_0000, 8'h88, 0, 0);
    run_scn("family_zero",  32'h7777_6666, 8'h81, 8'h80, 1, 32'hF3FF_FFFF, 8'h99, 1, 0);
    run_scn("busy_start",   32'hABCD_EF01, 8'hA0, 8'h80, 1, 32'h0400_0000, 8'hAB, 2, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule